// File: doc/BRIEF.md
# Baud Divisor Search Engine

This block picks the best pair of oversampling ratio and baud divisor for a serial port. It is given the frequency of the functional clock and the wanted baud rate. It tries every oversampling ratio from 4 to 32 and, for each one, two neighbouring integer divisors. It keeps the pair whose achieved rate comes closest to the wanted rate, judged by a fixed error rule and fixed tie-breaking rules. The result comes out as separate fields and also as one packed 32-bit control word, ready to be written to the baud configuration of a receiver or transmitter.

A request is given as a one-cycle `start` pulse while the block is idle. The block latches both inputs and raises `busy`. It then works through the candidates, using a single shared restoring divider that finds one quotient bit per cycle. It takes three divisions per ratio, about three thousand cycles in all. It ends with a one-cycle `done` pulse. The results stay unchanged until the next accepted request.

Top module: `baud_search_engine`

## Requirements
- R1: A `start` pulse while `busy` is low, with a nonzero baud input, sets `busy` high from the next cycle. `busy` stays high until the search ends. `done` is then high for exactly one cycle, with `busy` low in that cycle.
- R2: A `start` pulse while idle with a baud input of 0 starts no search. In the next cycle `done` and `zero_baud` are high and `busy` stays low. `osr_ratio`, `divisor`, `rate_error` and `baud_word` all read 0.
- R3: The candidate ratios are 4 through 32, taken in ascending order. For each ratio the first divisor is floor(clock / (baud × ratio)); a result of 0 is replaced by 1.
- R4: The error of a divisor d at ratio r is floor(clock / (r × d)) − baud, computed as an unsigned 32-bit difference that wraps. The error of d+1 is baud − floor(clock / (r × (d+1))), also a wrapping unsigned 32-bit difference.
- R5: The divisor d+1 replaces d only when its error is strictly smaller than the error of d. On equal errors d is kept.
- R6: The best error starts at the baud value, with ratio and divisor 0. A candidate replaces the best when its error is less than or equal to the best error, so on equal errors the larger ratio wins. `rate_error` reports the final best error.
- R7: `baud_word` holds the ratio minus 1 in bits 28:24 and the reported divisor in bits 12:0. It is all zeros while the reported ratio is 0.
- R8: Bit 17 of `baud_word`, which selects sampling on both edges, is 1 exactly when the reported ratio is in 4..7.
- R9: Bits 29 (10-bit mode) and 13 (second stop bit) of `baud_word` are always 0, and so are all other bits not named in R7 and R8.
- R10: A chosen divisor above 8191 is reported as 8191 on `divisor` and in the packed word.
- R11: A `start` pulse while `busy` is high is ignored. The running search and its result are unaffected.
- R12: After reset and after `done`, every result output holds its value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request pulse |
| ref_hz | input | 32 | Functional clock frequency in Hz |
| target_baud | input | 32 | Wanted baud rate |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| zero_baud | output | 1 | Last request had a baud of 0 |
| osr_ratio | output | 6 | Chosen oversampling ratio (4..32, 0 if none) |
| divisor | output | 13 | Chosen divisor, saturated to 8191 |
| rate_error | output | 32 | Unsigned error of the chosen pair |
| baud_word | output | 32 | Packed baud control word |

## Verification
The assertions assume that `start` is a clean synchronous pulse. They also assume that the products baud × 32 and ratio × (divisor + 1) fit in 32 bits, so the divider never receives a zero or truncated divisor. The stimulus keeps to this by using clock frequencies below 100 MHz and baud rates no higher than a few megabaud. The bench sweeps a grid of clock and baud values that covers divisors forced to 1, saturated divisors, exact ties between ratios and both-edge ratios. It also sends extra `start` pulses during a search and zero-baud requests, and compares each result with a reference model written from the requirements.

// File: rtl/baud_search_pkg.sv
package baud_search_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLOOR = 2'd1,
        ST_LOW   = 2'd2,
        ST_HIGH  = 2'd3
    } search_st_e;

endpackage

// File: rtl/baud_div_restoring.sv
module baud_div_restoring #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor_in,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic          run;
        logic          done;
    } div_s;

    div_s st_d, st_q;
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        shifted   = {st_q.rem, st_q.quo[W-1]};
        trial     = shifted - {1'b0, st_q.dvs};
        if (go) begin
            st_d.rem = '0;
            st_d.quo = dividend;
            st_d.dvs = divisor_in;
            st_d.cnt = CW'(W);
            st_d.run = 1'b1;
        end else if (st_q.run) begin
            if (shifted >= {1'b0, st_q.dvs}) begin
                st_d.rem = trial[W-1:0];
                st_d.quo = {st_q.quo[W-2:0], 1'b1};
            end else begin
                st_d.rem = shifted[W-1:0];
                st_d.quo = {st_q.quo[W-2:0], 1'b0};
            end
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done     = st_q.done;
    assign quotient = st_q.quo;

endmodule

// File: rtl/baud_word_pack.sv
module baud_word_pack #(
    parameter int RW      = 6,
    parameter int SBR_W   = 13,
    parameter int EDGE_LO = 4,
    parameter int EDGE_HI = 7
) (
    input  logic [RW-1:0]    ratio,
    input  logic [SBR_W-1:0] sbr,
    output logic [31:0]      word
);
    localparam int OSR_LSB  = 24;
    localparam int OSR_BITS = 5;
    localparam int EDGE_BIT = 17;

    logic [RW-1:0] ratio_m1;

    always_comb begin
        ratio_m1 = ratio - 1'b1;
        word     = '0;
        if (ratio != '0) begin
            word[SBR_W-1:0]                   = sbr;
            word[OSR_LSB +: OSR_BITS]         = ratio_m1[OSR_BITS-1:0];
            word[EDGE_BIT]                    = (ratio >= RW'(EDGE_LO)) && (ratio <= RW'(EDGE_HI));
        end
    end

endmodule

// File: rtl/baud_search_engine.sv
module baud_search_engine #(
    parameter int W      = 32,
    parameter int RW     = 6,
    parameter int SBR_W  = 13,
    parameter int OSR_LO = 4,
    parameter int OSR_HI = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     ref_hz,
    input  logic [W-1:0]     target_baud,
    output logic             busy,
    output logic             done,
    output logic             zero_baud,
    output logic [RW-1:0]    osr_ratio,
    output logic [SBR_W-1:0] divisor,
    output logic [W-1:0]     rate_error,
    output logic [31:0]      baud_word
);
    import baud_search_pkg::*;

    localparam logic [W-1:0] SBR_MAX = W'((1 << SBR_W) - 1);

    typedef struct packed {
        search_st_e       st;
        logic [W-1:0]     clk_v;
        logic [W-1:0]     baud_v;
        logic [RW-1:0]    ratio;
        logic [W-1:0]     sbr;
        logic [W-1:0]     diff_lo;
        logic [W-1:0]     best_diff;
        logic [RW-1:0]    best_ratio;
        logic [W-1:0]     best_sbr;
        logic [W-1:0]     dvs;
        logic             go;
        logic             done;
        logic             zerr;
        logic [RW-1:0]    out_ratio;
        logic [SBR_W-1:0] out_sbr;
        logic [W-1:0]     out_diff;
    } eng_s;

    eng_s r_d, r_q;

    logic         div_done;
    logic [W-1:0] div_quo;

    logic [W-1:0]  q_floor;
    logic [W-1:0]  diff_hi;
    logic [W-1:0]  cand_diff;
    logic [W-1:0]  cand_sbr;
    logic [W-1:0]  nb_diff;
    logic [RW-1:0] nb_ratio;
    logic [W-1:0]  nb_sbr;
    logic [RW-1:0] ratio_nx;

    always_comb begin
        r_d       = r_q;
        r_d.go    = 1'b0;
        r_d.done  = 1'b0;
        q_floor   = (div_quo == '0) ? W'(1) : div_quo;
        diff_hi   = r_q.baud_v - div_quo;
        cand_diff = r_q.diff_lo;
        cand_sbr  = r_q.sbr;
        if (r_q.diff_lo > diff_hi) begin
            cand_diff = diff_hi;
            cand_sbr  = r_q.sbr + 1'b1;
        end
        nb_diff  = r_q.best_diff;
        nb_ratio = r_q.best_ratio;
        nb_sbr   = r_q.best_sbr;
        if (cand_diff <= r_q.best_diff) begin
            nb_diff  = cand_diff;
            nb_ratio = r_q.ratio;
            nb_sbr   = cand_sbr;
        end
        ratio_nx = r_q.ratio + 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (target_baud == '0) begin
                        r_d.done      = 1'b1;
                        r_d.zerr      = 1'b1;
                        r_d.out_ratio = '0;
                        r_d.out_sbr   = '0;
                        r_d.out_diff  = '0;
                    end else begin
                        r_d.zerr       = 1'b0;
                        r_d.clk_v      = ref_hz;
                        r_d.baud_v     = target_baud;
                        r_d.ratio      = RW'(OSR_LO);
                        r_d.best_diff  = target_baud;
                        r_d.best_ratio = '0;
                        r_d.best_sbr   = '0;
                        r_d.dvs        = target_baud * W'(OSR_LO);
                        r_d.go         = 1'b1;
                        r_d.st         = ST_FLOOR;
                    end
                end
            end
            ST_FLOOR: begin
                if (div_done) begin
                    r_d.sbr = q_floor;
                    r_d.dvs = W'(r_q.ratio) * q_floor;
                    r_d.go  = 1'b1;
                    r_d.st  = ST_LOW;
                end
            end
            ST_LOW: begin
                if (div_done) begin
                    r_d.diff_lo = div_quo - r_q.baud_v;
                    r_d.dvs     = W'(r_q.ratio) * (r_q.sbr + 1'b1);
                    r_d.go      = 1'b1;
                    r_d.st      = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (div_done) begin
                    r_d.best_diff  = nb_diff;
                    r_d.best_ratio = nb_ratio;
                    r_d.best_sbr   = nb_sbr;
                    if (r_q.ratio == RW'(OSR_HI)) begin
                        r_d.done      = 1'b1;
                        r_d.out_ratio = nb_ratio;
                        r_d.out_sbr   = (nb_sbr > SBR_MAX) ? SBR_MAX[SBR_W-1:0] : nb_sbr[SBR_W-1:0];
                        r_d.out_diff  = nb_diff;
                        r_d.st        = ST_IDLE;
                    end else begin
                        r_d.ratio = ratio_nx;
                        r_d.dvs   = r_q.baud_v * W'(ratio_nx);
                        r_d.go    = 1'b1;
                        r_d.st    = ST_FLOOR;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    baud_div_restoring #(.W(W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (r_q.go),
        .dividend  (r_q.clk_v),
        .divisor_in(r_q.dvs),
        .done      (div_done),
        .quotient  (div_quo)
    );

    baud_word_pack #(.RW(RW), .SBR_W(SBR_W), .EDGE_LO(4), .EDGE_HI(7)) u_pack (
        .ratio(r_q.out_ratio),
        .sbr  (r_q.out_sbr),
        .word (baud_word)
    );

    assign busy       = (r_q.st != ST_IDLE);
    assign done       = r_q.done;
    assign zero_baud  = r_q.zerr;
    assign osr_ratio  = r_q.out_ratio;
    assign divisor    = r_q.out_sbr;
    assign rate_error = r_q.out_diff;

endmodule

// File: rtl/baud_search_checker.sv
module baud_search_checker #(
    parameter int W     = 32,
    parameter int RW    = 6,
    parameter int SBR_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [W-1:0]     target_baud,
    input logic             busy,
    input logic             done,
    input logic             zero_baud,
    input logic [RW-1:0]    osr_ratio,
    input logic [SBR_W-1:0] divisor,
    input logic [W-1:0]     rate_error,
    input logic [31:0]      baud_word
);
    a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && target_baud != '0) |=> busy);

    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r2_zero_request: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && target_baud == '0) |=> (done && zero_baud && !busy && baud_word == '0));

    a_r6_ratio_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !zero_baud) |-> (osr_ratio >= RW'(4) && osr_ratio <= RW'(32) && divisor != '0));

    a_r7_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (osr_ratio != '0) |-> (baud_word[12:0] == divisor && baud_word[28:24] == 5'(osr_ratio - 1'b1)));

    a_r8_both_edge: assert property (@(posedge clk) disable iff (!rst_n)
        baud_word[17] == (osr_ratio >= RW'(4) && osr_ratio <= RW'(7)));

    a_r9_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_word[29] && !baud_word[13] && baud_word[31:30] == '0 && baud_word[23:18] == '0 && baud_word[16:14] == '0));

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(baud_word) && $stable(rate_error) && $stable(osr_ratio)));

endmodule

bind baud_search_engine baud_search_checker #(.W(W), .RW(RW), .SBR_W(SBR_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .target_baud(target_baud),
    .busy       (busy),
    .done       (done),
    .zero_baud  (zero_baud),
    .osr_ratio  (osr_ratio),
    .divisor    (divisor),
    .rate_error (rate_error),
    .baud_word  (baud_word)
);

// File: tb/test_baud_search_engine.sv
module test_baud_search_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ref_hz = '0;
    logic [31:0] target_baud = '0;
    logic        busy, done, zero_baud;
    logic [5:0]  osr_ratio;
    logic [12:0] divisor;
    logic [31:0] rate_error, baud_word;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    baud_search_engine i_baud_search_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz),
        .target_baud(target_baud), .busy(busy), .done(done),
        .zero_baud(zero_baud), .osr_ratio(osr_ratio), .divisor(divisor),
        .rate_error(rate_error), .baud_word(baud_word)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference built from R3..R6 and R10
    task automatic model(input logic [31:0] c, input logic [31:0] b,
                         output logic [5:0] br, output logic [12:0] bs, output logic [31:0] bd);
        logic [31:0] best_s;
        bd = b; br = '0; best_s = '0;
        for (int r = 4; r <= 32; r++) begin
            logic [31:0] rr, q, d1, d2;
            rr = 32'(r);
            q  = c / (b * rr);
            if (q == 0) q = 1;
            d1 = (c / (rr * q)) - b;
            d2 = b - (c / (rr * (q + 1)));
            if (d1 > d2) begin d1 = d2; q = q + 1; end
            if (d1 <= bd) begin bd = d1; br = 6'(r); best_s = q; end
        end
        bs = (best_s > 32'd8191) ? 13'd8191 : best_s[12:0];
    endtask

    function automatic logic [31:0] pack(input logic [5:0] r, input logic [12:0] s);
        logic [31:0] w;
        logic [5:0] m;
        w = '0;
        m = r - 1;
        if (r != 0) begin
            w[12:0]  = s;
            w[28:24] = m[4:0];
            w[17]    = (r >= 4 && r <= 7);
        end
        return w;
    endfunction

    task automatic run_case(input logic [31:0] c, input logic [31:0] b, input bit poke);
        logic [5:0]  er;
        logic [12:0] es;
        logic [31:0] ed;
        int n;
        model(c, b, er, es, ed);
        @(negedge clk);
        ref_hz = c; target_baud = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", longint'(busy), 1);
        n = 0;
        while (!done && n < 6000) begin
            if (poke && n == 200) begin
                ref_hz = 32'd12345; target_baud = 32'd7; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(done == 1'b1, "R1 done reached", longint'(done), 1);
        chk(busy == 1'b0, "R1 idle at done", longint'(busy), 0);
        chk(osr_ratio == er, poke ? "R11 ratio after ignored start" : "R3 ratio", longint'(osr_ratio), longint'(er));
        chk(divisor == es, "R5 divisor", longint'(divisor), longint'(es));
        chk(rate_error == ed, "R6 error", longint'(rate_error), longint'(ed));
        chk(baud_word == pack(er, es), "R7 word", longint'(baud_word), longint'(pack(er, es)));
        chk(zero_baud == 1'b0, "R2 no zero flag", longint'(zero_baud), 0);
        @(negedge clk);
        chk(done == 1'b0, "R1 done one cycle", longint'(done), 0);
        target_baud = 32'd999;
        repeat (3) @(negedge clk);
        chk(baud_word == pack(er, es), "R12 hold", longint'(baud_word), longint'(pack(er, es)));
    endtask

    initial begin
        logic [31:0] clks [4];
        logic [31:0] bauds [5];
        clks  = '{32'd24000000, 32'd48000000, 32'd80000000, 32'd2000};
        bauds = '{32'd115200, 32'd9600, 32'd3000000, 32'd300, 32'd700};
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && baud_word == 0 && osr_ratio == 0, "R12 reset state",
            longint'(baud_word), 0);
        rst_n = 1'b1;
        @(negedge clk);
        foreach (clks[i]) begin
            foreach (bauds[j]) begin
                if (!(clks[i] == 32'd2000 && bauds[j] > 32'd700))
                    run_case(clks[i], bauds[j], 1'b0);
            end
        end
        // R8 ratio 5 exact, both-edge bit set
        run_case(32'd20000000, 32'd4000000, 1'b0);
        chk(baud_word[17] == 1'b1, "R8 both edge", longint'(baud_word[17]), 1);
        chk(baud_word[29] == 1'b0 && baud_word[13] == 1'b0, "R9 cleared bits", longint'(baud_word), 0);
        // R6 tie: ratio 8 beats ratio 4
        run_case(32'd24000000, 32'd3000000, 1'b0);
        chk(osr_ratio == 6'd8, "R6 tie larger ratio", longint'(osr_ratio), 8);
        // R10 saturation
        run_case(32'd80000000, 32'd300, 1'b0);
        chk(divisor == 13'd8191, "R10 saturate", longint'(divisor), 8191);
        // R3 forced divisor of one
        run_case(32'd2000, 32'd700, 1'b0);
        chk(divisor >= 13'd1, "R3 forced one", longint'(divisor), 1);
        // R4 wrapped error path exercised with small clock
        run_case(32'd1000, 32'd999, 1'b0);
        chk(rate_error <= 32'd999, "R4 error bound", longint'(rate_error), 999);
        // R11 start pulse during search
        run_case(32'd48000000, 32'd115200, 1'b1);
        // R2 zero baud
        @(negedge clk);
        target_baud = 32'd0; ref_hz = 32'd48000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1 && zero_baud == 1'b1, "R2 zero done", longint'(zero_baud), 1);
        chk(busy == 1'b0, "R2 no search", longint'(busy), 0);
        chk(baud_word == 0 && osr_ratio == 0 && divisor == 0 && rate_error == 0,
            "R2 zero outputs", longint'(baud_word), 0);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R2 stays idle", longint'(busy), 0);
        finished = 1'b1;
    end

    initial begin
        while (!finished && cycles < WATCHDOG) @(negedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule